// File: doc/BRIEF.md
# Oversampled Bit-Cell Clock Recovery and Line Decoder

This block recovers bit timing and data from a serial line that carries no separate clock. The raw line passes through a two-flop synchroniser. It is then sampled once per sample tick, and there are sixteen ticks in each nominal bit cell. A 4-bit phase counter acts as a digital phase-locked loop. When an edge lands close to the expected cell boundary, the counter is nudged one step in the direction that moves that edge back to phase 0. Cells that carry no edge are coasted through at the nominal rate.

Three line codes are supported, and a static mode input selects between them. The two biphase codes guarantee a transition at every cell boundary and carry the data in whether a transition also occurs near mid-cell. In the NRZI code, a change of level between successive cell centres means 0.

For each cell the block emits a one-cycle strobe together with the decoded bit. It also drives a code-violation pulse when a biphase boundary transition is missing, and a lock flag that is set after a run of well-placed boundary edges and cleared after repeated violations.

Top module: `cell_clock_recovery`

## Requirements
- R1: The phase counter advances once per sample tick and wraps after 16 ticks. The block produces exactly one decoded bit per 16 ticks on a steady line.
- R2: With mode = 2'b01 (biphase, mid-cell edge means 0), a cell with an edge in phases 5 to 11 decodes as 0, and a cell without one decodes as 1.
- R3: With mode = 2'b10 (biphase, mid-cell edge means 1), a cell with an edge in phases 5 to 11 decodes as 1, and a cell without one decodes as 0.
- R4: With mode = 2'b00 or 2'b11 (NRZI), the line level sampled at phase 8 is compared with the level sampled at phase 8 of the previous cell. Equal levels decode as 1 and a change decodes as 0. Edgeless cells coast with no loss of timing. This mode never raises a code violation.
- R5: An edge seen at phases 1 to 4 holds the phase counter for one tick. An edge seen at phases 12 to 15 advances it by two. As a result, a boundary that shifts by two ticks is followed without any decode error or violation.
- R6: In either biphase mode, a cell with no edge in phases 12 to 15 or 0 to 4 raises codeViol for exactly the cycle in which that cell's bitValid is high.
- R7: The locked output rises after 8 consecutive cells that have a boundary-window edge and no violation. In NRZI mode, edgeless cells neither count toward that run nor break it.
- R8: While locked, the fourth code violation clears locked.
- R9: While rstN is low, bitValid, codeViol and locked are 0. Reset also clears lock that was already acquired.
- R10: bitValid is a single-cycle pulse, and bitData is meaningful only while it is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Active-low synchronous reset |
| mode | input | 2 | Line code: 00/11 NRZI, 01 biphase mid-edge=0, 10 biphase mid-edge=1 |
| lineIn | input | 1 | Raw asynchronous serial line |
| bitValid | output | 1 | One-cycle strobe per decoded cell |
| bitData | output | 1 | Decoded bit, valid with bitValid |
| locked | output | 1 | Phase tracking has acquired the line |
| codeViol | output | 1 | Missing biphase boundary transition, pulses with bitValid |

## Verification
The bench builds the block with its default parameters: 16 phases, a lock run of 8, an unlock count of 4, and a tick divider of 1. With a divider of 1 every clock is a sample, so each bit cell is exactly 16 clocks. This keeps every phase window, the one-tick hold, the two-tick skip, the lock run and the unlock count reachable within a few hundred cycles per vector. Each vector also shifts the line by a known amount relative to the counter, so the boundary edges arrive at phase 0 and a deliberately stretched cell moves them into the early-hold window.

// File: rtl/ccr_pkg.sv
package ccr_pkg;
  typedef struct packed {
    logic phHold;
    logic phSkip;
  } phaseStrobe_t;

  typedef enum logic [1:0] {
    LINE_NRZI  = 2'b00,
    LINE_BP0   = 2'b01,
    LINE_BP1   = 2'b10,
    LINE_NRZI2 = 2'b11
  } lineMode_e;
endpackage

// File: rtl/ccr_datapath.sv
module ccr_datapath
  import ccr_pkg::*;
#(
  parameter int OSR      = 16,
  parameter int TICK_DIV = 1,
  localparam int PH_W    = $clog2(OSR)
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            lineIn,
  input  phaseStrobe_t    strobe,
  output logic            tick,
  output logic            edgeSeen,
  output logic [PH_W-1:0] phase,
  output logic            centreLvl,
  output logic            prevCentreLvl
);
  localparam logic [PH_W-1:0] CENTRE = PH_W'(OSR / 2);

  logic syncA, syncB, lastLvl;

  generate
    if (TICK_DIV == 1) begin : g_noDiv
      assign tick = 1'b1;
    end else begin : g_div
      localparam int DW = $clog2(TICK_DIV);
      logic [DW-1:0] divCnt;
      always_ff @(posedge clk) begin
        if (!rstN) divCnt <= '0;
        else if (divCnt == DW'(TICK_DIV - 1)) divCnt <= '0;
        else divCnt <= divCnt + 1'b1;
      end
      assign tick = (divCnt == '0);
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) begin
      syncA <= 1'b0;
      syncB <= 1'b0;
    end else begin
      syncA <= lineIn;
      syncB <= syncA;
    end
  end

  assign edgeSeen = tick && (syncB != lastLvl);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lastLvl       <= 1'b0;
      phase         <= '0;
      centreLvl     <= 1'b0;
      prevCentreLvl <= 1'b0;
    end else if (tick) begin
      lastLvl <= syncB;
      if (strobe.phHold)      phase <= phase;
      else if (strobe.phSkip) phase <= phase + PH_W'(2);
      else                    phase <= phase + 1'b1;
      if (phase == CENTRE) begin
        centreLvl     <= syncB;
        prevCentreLvl <= centreLvl;
      end
    end
  end
endmodule

// File: rtl/ccr_control.sv
module ccr_control
  import ccr_pkg::*;
#(
  parameter int OSR         = 16,
  parameter int LOCK_CELLS  = 8,
  parameter int UNLOCK_VIOL = 4,
  localparam int PH_W       = $clog2(OSR),
  localparam int GW         = $clog2(LOCK_CELLS + 1),
  localparam int VW         = $clog2(UNLOCK_VIOL + 1)
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic [1:0]      mode,
  input  logic            tick,
  input  logic            edgeSeen,
  input  logic [PH_W-1:0] phase,
  input  logic            centreLvl,
  input  logic            prevCentreLvl,
  output phaseStrobe_t    strobe,
  output logic            bitValid,
  output logic            bitData,
  output logic            locked,
  output logic            codeViol
);
  localparam int Q = OSR / 4;
  localparam logic [PH_W-1:0] EARLY_HI  = PH_W'(Q);
  localparam logic [PH_W-1:0] LATE_LO   = PH_W'(OSR - Q);
  localparam logic [PH_W-1:0] CELL_HEAD = PH_W'(OSR - Q);
  localparam logic [PH_W-1:0] CELL_TAIL = PH_W'(OSR - Q - 1);

  logic inBnd, inMid, bndSeen, midSeen, bndAll, midAll, isBp0, isBp1, isBp;
  logic [GW-1:0] goodRun;
  logic [VW-1:0] violCnt;

  assign isBp0 = (mode == LINE_BP0);
  assign isBp1 = (mode == LINE_BP1);
  assign isBp  = isBp0 || isBp1;

  assign inBnd = (phase >= LATE_LO) || (phase <= EARLY_HI);
  assign inMid = !inBnd;

  always_comb begin
    strobe.phHold = edgeSeen && (phase != '0) && (phase <= EARLY_HI);
    strobe.phSkip = edgeSeen && (phase >= LATE_LO);
  end

  assign bndAll = bndSeen || (edgeSeen && inBnd);
  assign midAll = midSeen || (edgeSeen && inMid);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      bndSeen  <= 1'b0;
      midSeen  <= 1'b0;
      goodRun  <= '0;
      violCnt  <= '0;
      locked   <= 1'b0;
      bitValid <= 1'b0;
      bitData  <= 1'b0;
      codeViol <= 1'b0;
    end else begin
      bitValid <= 1'b0;
      codeViol <= 1'b0;
      if (tick) begin
        if (phase == CELL_HEAD) begin
          bndSeen <= edgeSeen && inBnd;
          midSeen <= edgeSeen && inMid;
        end else begin
          bndSeen <= bndAll;
          midSeen <= midAll;
        end
        if (phase == CELL_TAIL) begin
          bitValid <= 1'b1;
          if (isBp) bitData <= isBp1 ? midAll : !midAll;
          else      bitData <= (centreLvl == prevCentreLvl);
          if (isBp && !bndAll) begin
            codeViol <= 1'b1;
            goodRun  <= '0;
            if (locked) begin
              if (violCnt == VW'(UNLOCK_VIOL - 1)) begin
                locked  <= 1'b0;
                violCnt <= '0;
              end else begin
                violCnt <= violCnt + 1'b1;
              end
            end
          end else if (!isBp && midAll) begin
            goodRun <= '0;
          end else if (bndAll && !locked) begin
            if (goodRun == GW'(LOCK_CELLS - 1)) begin
              locked  <= 1'b1;
              goodRun <= '0;
              violCnt <= '0;
            end else begin
              goodRun <= goodRun + 1'b1;
            end
          end
        end
      end
    end
  end
endmodule

// File: rtl/cell_clock_recovery.sv
module cell_clock_recovery
  import ccr_pkg::*;
#(
  parameter int OSR         = 16,
  parameter int TICK_DIV    = 1,
  parameter int LOCK_CELLS  = 8,
  parameter int UNLOCK_VIOL = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [1:0] mode,
  input  logic       lineIn,
  output logic       bitValid,
  output logic       bitData,
  output logic       locked,
  output logic       codeViol
);
  localparam int PH_W = $clog2(OSR);

  phaseStrobe_t    strobe;
  logic            tick, edgeSeen, centreLvl, prevCentreLvl;
  logic [PH_W-1:0] phase;

  ccr_datapath #(.OSR(OSR), .TICK_DIV(TICK_DIV)) u_dp (
    .clk(clk), .rstN(rstN), .lineIn(lineIn), .strobe(strobe),
    .tick(tick), .edgeSeen(edgeSeen), .phase(phase),
    .centreLvl(centreLvl), .prevCentreLvl(prevCentreLvl)
  );

  ccr_control #(.OSR(OSR), .LOCK_CELLS(LOCK_CELLS), .UNLOCK_VIOL(UNLOCK_VIOL)) u_ctl (
    .clk(clk), .rstN(rstN), .mode(mode), .tick(tick), .edgeSeen(edgeSeen),
    .phase(phase), .centreLvl(centreLvl), .prevCentreLvl(prevCentreLvl),
    .strobe(strobe), .bitValid(bitValid), .bitData(bitData),
    .locked(locked), .codeViol(codeViol)
  );
endmodule

// File: rtl/ccr_checker.sv
module ccr_checker (
  input logic       clk,
  input logic       rstN,
  input logic [1:0] mode,
  input logic       bitValid,
  input logic       locked,
  input logic       codeViol
);
  AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    bitValid |=> !bitValid); // R10
  AST_VIOL_WITH_VALID: assert property (@(posedge clk) disable iff (!rstN)
    codeViol |-> bitValid); // R6
  AST_NRZI_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (mode == 2'b00 || mode == 2'b11) |-> !codeViol); // R4
  AST_LOCK_RISE_CLEAN: assert property (@(posedge clk) disable iff (!rstN)
    $rose(locked) |-> (bitValid && !codeViol)); // R7
  AST_LOCK_FALL_VIOL: assert property (@(posedge clk) disable iff (!rstN)
    $fell(locked) |-> codeViol); // R8
endmodule

bind cell_clock_recovery ccr_checker u_ccr_checker (
  .clk(clk), .rstN(rstN), .mode(mode), .bitValid(bitValid),
  .locked(locked), .codeViol(codeViol)
);

// File: tb/cell_clock_recovery_bench.sv
module cell_clock_recovery_bench;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [1:0] mode = 2'b01;
  logic lineIn = 1'b0;
  logic bitValid, bitData, locked, codeViol;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  int   rxCnt = 0;
  logic rxBit [64];
  logic rxViol [64];
  int   doublePulse = 0;
  logic lastValid = 1'b0;

  always #5 clk = ~clk;

  cell_clock_recovery u_cell_clock_recovery (
    .clk(clk), .rstN(rstN), .mode(mode), .lineIn(lineIn),
    .bitValid(bitValid), .bitData(bitData), .locked(locked), .codeViol(codeViol)
  );

  always @(negedge clk) begin
    if (rstN && bitValid) begin
      if (rxCnt < 64) begin
        rxBit[rxCnt]  = bitData;
        rxViol[rxCnt] = codeViol;
      end
      rxCnt = rxCnt + 1;
      if (lastValid) doublePulse = doublePulse + 1;
    end
    lastValid = bitValid;
  end

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // {mode[1:0], data[15:0], omitBoundary[15:0], expLock, stretchCell[4:0]}
  localparam logic [39:0] VECS [7] = '{
    {2'b01, 16'hA5C3, 16'h0000, 1'b1, 5'd31},
    {2'b10, 16'h3C96, 16'h0000, 1'b1, 5'd31},
    {2'b00, 16'h1248, 16'h0000, 1'b1, 5'd31},
    {2'b01, 16'hFFFF, 16'h0000, 1'b1, 5'd31},
    {2'b10, 16'h0000, 16'h0000, 1'b1, 5'd31},
    {2'b01, 16'h5A5A, 16'h3C00, 1'b0, 5'd31},
    {2'b10, 16'hC35A, 16'h0000, 1'b1, 5'd6}
  };

  task automatic doReset(input logic [1:0] m);
    @(negedge clk);
    rstN = 1'b0;
    mode = m;
    lineIn = 1'b0;
    repeat (3) @(negedge clk);
    rxCnt = 0;
    doublePulse = 0;
    rstN = 1'b1;
  endtask

  // Cycle t=0 is the negedge before the first sampled edge; boundary of cell k at 16k+14.
  task automatic driveCells(input logic [1:0] m, input logic [15:0] data,
                            input logic [15:0] omit, input int stretchAt);
    bit bp, bp1;
    int endT;
    bp  = (m == 2'b01) || (m == 2'b10);
    bp1 = (m == 2'b10);
    endT = 16 * 16 + 14 + 30;
    for (int t = 0; t < endT; t++) begin
      for (int k = 0; k < 16; k++) begin
        int b;
        b = 16 * k + 14 + ((k >= stretchAt) ? 2 : 0);
        if (t == b) begin
          if (bp) begin
            if (!omit[k]) lineIn = ~lineIn;
          end else if (!data[k]) begin
            lineIn = ~lineIn;
          end
        end
        if (bp && t == b + 8 && (data[k] == bp1)) lineIn = ~lineIn;
      end
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (4) @(negedge clk);
    // R9: reset state
    check("R9 bitValid in reset", bitValid, 0);
    check("R9 locked in reset", locked, 0);
    check("R9 codeViol in reset", codeViol, 0);

    for (int v = 0; v < 7; v++) begin
      logic [1:0]  m;
      logic [15:0] d, om;
      logic        el;
      int          st;
      string       reqBit;
      m  = VECS[v][39:38];
      d  = VECS[v][37:22];
      om = VECS[v][21:6];
      el = VECS[v][5];
      st = int'(VECS[v][4:0]);
      reqBit = (m == 2'b01) ? "R2" : (m == 2'b10) ? "R3" : "R4";
      if (st < 16) reqBit = "R5";
      doReset(m);
      driveCells(m, d, om, st);
      check("R1 one bit per 16 ticks", (rxCnt >= 17 && rxCnt <= 19) ? 1 : 0, 1);
      check("R10 single-cycle bitValid", doublePulse, 0);
      for (int k = 0; k < 16; k++) begin
        check(reqBit, rxBit[k + 1], d[k]);
        check("R6 violation flag", rxViol[k + 1], om[k]);
      end
      check(el ? "R7 lock acquired" : "R8 lock dropped", locked, el);
    end

    // R9: reset clears an acquired lock
    doReset(2'b01);
    driveCells(2'b01, 16'h0F0F, 16'h0000, 31);
    check("R7 lock before reset", locked, 1);
    @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    @(negedge clk);
    check("R9 lock cleared by reset", locked, 0);
    check("R9 valid low in reset", bitValid, 0);
    rstN = 1'b1;

    // R4: NRZI all ones, no edges at all: coasting keeps bits, no lock, no violation
    doReset(2'b11);
    driveCells(2'b11, 16'hFFFF, 16'h0000, 31);
    for (int k = 0; k < 16; k++) check("R4 coast", rxBit[k + 1], 1);
    check("R4 no violation in NRZI", rxViol[5], 0);
    check("R7 no edges no lock", locked, 0);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #1500000;
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule